// File: doc/BRIEF.md
# I2C Serial-Memory Target Controller

This block is the target side of a two-wire serial bus in front of a 16K-byte memory. It samples SCL and SDA in the system clock domain and finds start and stop conditions. It then receives a device address byte and matches it against a fixed family code and three strap pins. For a write it collects a two-byte word address and forwards each data byte to a separate page-write unit. For a read it serves bytes from an array read port. SDA is open-drain: the block only ever asserts a drive-low enable.

A single address counter serves every read type. A current-address read uses the counter as it stands. A random read loads the counter with a dummy write header and then switches to a read header after a repeated start. A sequential read advances the counter on every host acknowledge and wraps over the whole array. While the page-write unit reports busy, the device address is not acknowledged, so a host can poll for completion by repeating start plus address.

Top module: `i2c_mem_target`

## Requirements
- R1: Start is SDA falling while SCL is high, and stop is SDA rising while SCL is high. The drive-low output changes only while SCL is low.
- R2: The device address byte is sent MSB first. Its upper seven bits must equal binary 1010 followed by the three strap pins, and bit 0 is R/W (1 = read, 0 = write). On a match the block drives SDA low during the ninth clock. On a mismatch it drives nothing until the next start.
- R3: While wr_busy is high at the end of a device address byte, that byte is not acknowledged. When wr_busy is low, the same byte is acknowledged.
- R4: After a write header, the word address arrives as two acknowledged bytes, most significant first. The top two bits of the first byte are ignored.
- R5: Each write data byte is acknowledged and presented for one cycle on wr_valid, with wr_addr and wr_data. Between data bytes only the low six address bits increment, and they wrap inside the 64-byte page.
- R6: A stop that follows at least one write data byte gives a single one-cycle wr_commit pulse. A dummy write, an unacknowledged header or a read gives none.
- R7: A read header with no new word address returns the byte at the shared counter. The counter holds the last accessed location plus one; after a write that increment is the page-wrapped one. After the top location it holds location 0.
- R8: A write header with a word address, followed by a repeated start and a read header, returns the byte at that word address first.
- R9: During a read, each host acknowledge (SDA low on the ninth clock) makes the block send the byte at the next address. Address 16383 is followed by address 0.
- R10: A host not-acknowledge ends the read. SDA stays released for every further clock until the next start.
- R11: A start seen in the middle of a byte abandons that byte and restarts bit counting, so the following header is received correctly.
- R12: After reset SDA is released, and wr_valid and wr_commit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap | input | 3 | Device address strap bits |
| wr_busy | input | 1 | Page-write unit is programming |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 14 | Array address of the write byte |
| wr_data | output | 8 | Write byte value |
| wr_commit | output | 1 | One-cycle pulse: stop ended a write with data |
| rd_addr | output | 14 | Array read address (the shared counter) |
| rd_data | input | 8 | Array read data for rd_addr |

## Verification
The hardest case to reach from the ports is a sequential read that crosses from location 16383 to location 0 while the host keeps acknowledging. The bench gets there with a dummy write to 16382, a repeated start into a read header and three received bytes. After the host's not-acknowledge it clocks one more bit to show that SDA stays released. A second hard case is a start that cuts a header off after four bits. The bench sends a partial byte and then a repeated start, and the next full read header must still be acknowledged and return the byte at the counter.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  localparam logic [3:0] DEV_FAMILY = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WAH,
    ST_WAL,
    ST_WDAT,
    ST_RDAT,
    ST_LOCKOUT
  } tgt_state_e;

  typedef enum logic {
    PH_BITS,
    PH_ACK
  } slot_e;

  // Device header match: family code followed by strap bits
  function automatic logic dev_hit(input logic [7:0] hdr, input logic [2:0] strap_bits);
    return hdr[7:1] == {DEV_FAMILY, strap_bits};
  endfunction

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
      scl_p  <= scl_sh[SYNC_STAGES-1];
      sda_p  <= sda_sh[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_sh[SYNC_STAGES-1];
  assign sda_s    = sda_sh[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // Both samples of SCL high, so a simultaneous SCL/SDA change is no condition
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, scl_rise, scl_fall})); // R1

endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int AW = 14,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step_seq,
  input  logic          step_page,
  output logic [AW-1:0] ctr
);

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  // Whole-array increment with wrap from the top location to 0
  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a);
    return (a == TOP_ADDR) ? '0 : a + 1'b1;
  endfunction

  // Increment confined to the low page bits
  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
    logic [PW-1:0] lo;
    lo = a[PW-1:0] + 1'b1;
    return {a[AW-1:PW], lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctr <= '0;
    else if (load)      ctr <= load_val;
    else if (step_page) ctr <= page_next(ctr);
    else if (step_seq)  ctr <= seq_next(ctr);
  end

  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !load) |=> ctr[AW-1:PW] == $past(ctr[AW-1:PW])); // R5

  AST_SEQ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_seq && !load && !step_page && ctr == TOP_ADDR) |=> ctr == '0); // R9

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  input  logic [2:0]        strap,
  input  logic              wr_busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);

  localparam int HI_W = ADDR_W - 8;

  // Conditioned bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  tgt_state_e        st, st_nxt_q;
  slot_e             ph;
  logic [3:0]        bit_cnt;
  logic [7:0]        rx_sh, tx_sh;
  logic              oe;
  logic              host_ack;
  logic              have_data;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ctr_q;

  // Named internal events
  logic rx_state, byte_done_ev, rx_byte_ev, tx_byte_ev, slot_end_ev;
  logic dev_ok, ack_now, wr_fire, ctr_load, tx_shift_ev;

  assign rx_state     = (st == ST_DEV) || (st == ST_WAH) || (st == ST_WAL) || (st == ST_WDAT);
  assign byte_done_ev = scl_fall && (ph == PH_BITS) && (bit_cnt == 4'd8) &&
                        (rx_state || (st == ST_RDAT));
  assign rx_byte_ev   = byte_done_ev && rx_state;
  assign tx_byte_ev   = byte_done_ev && (st == ST_RDAT);
  assign tx_shift_ev  = scl_fall && (st == ST_RDAT) && (ph == PH_BITS) && (bit_cnt != 4'd8);
  assign slot_end_ev  = scl_fall && (ph == PH_ACK) && (rx_state || (st == ST_RDAT));
  assign dev_ok       = dev_hit(rx_sh, strap) && !wr_busy;
  assign ack_now      = rx_byte_ev && ((st != ST_DEV) || dev_ok);
  assign wr_fire      = rx_byte_ev && (st == ST_WDAT);
  assign ctr_load     = rx_byte_ev && (st == ST_WAL);

  i2c_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctr_load),
    .load_val  ({hi_q, rx_sh}),
    .step_seq  (tx_byte_ev),
    .step_page (wr_fire),
    .ctr       (ctr_q)
  );

  assign rd_addr       = ctr_q;
  assign sda_drive_low = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      st_nxt_q  <= ST_IDLE;
      ph        <= PH_BITS;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      oe        <= 1'b0;
      host_ack  <= 1'b0;
      have_data <= 1'b0;
      hi_q      <= '0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_valid  <= 1'b0;
      wr_commit <= 1'b0;
      if (start_ev) begin
        st      <= ST_DEV;
        ph      <= PH_BITS;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else if (stop_ev) begin
        st        <= ST_IDLE;
        ph        <= PH_BITS;
        bit_cnt   <= '0;
        oe        <= 1'b0;
        wr_commit <= have_data;
        have_data <= 1'b0;
      end else begin
        // Receive: sample on rising SCL
        if (rx_state && (ph == PH_BITS) && scl_rise && (bit_cnt < 4'd8)) begin
          rx_sh   <= {rx_sh[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end
        // Receive: byte complete, enter acknowledge slot
        if (rx_byte_ev) begin
          ph      <= PH_ACK;
          bit_cnt <= '0;
          oe      <= ack_now;
          case (st)
            ST_DEV: begin
              if (!dev_ok) begin
                st <= ST_LOCKOUT;
                ph <= PH_BITS;
              end else begin
                st_nxt_q <= rx_sh[0] ? ST_RDAT : ST_WAH;
              end
            end
            ST_WAH: begin
              hi_q     <= rx_sh[HI_W-1:0];
              st_nxt_q <= ST_WAL;
            end
            ST_WAL:  st_nxt_q <= ST_WDAT;
            default: begin
              wr_valid  <= 1'b1;
              wr_addr   <= ctr_q;
              wr_data   <= rx_sh;
              have_data <= 1'b1;
              st_nxt_q  <= ST_WDAT;
            end
          endcase
        end
        // Transmit: shift next bit out on falling SCL
        if (tx_shift_ev) begin
          tx_sh   <= {tx_sh[6:0], 1'b0};
          oe      <= ~tx_sh[6];
          bit_cnt <= bit_cnt + 4'd1;
        end
        // Transmit: byte complete, release for host acknowledge
        if (tx_byte_ev) begin
          ph      <= PH_ACK;
          oe      <= 1'b0;
          bit_cnt <= '0;
        end
        if ((st == ST_RDAT) && (ph == PH_ACK) && scl_rise) begin
          host_ack <= ~sda_s;
        end
        // End of any acknowledge slot
        if (slot_end_ev) begin
          ph <= PH_BITS;
          if ((rx_state && (st_nxt_q == ST_RDAT)) || ((st == ST_RDAT) && host_ack)) begin
            st      <= ST_RDAT;
            tx_sh   <= rd_data;
            oe      <= ~rd_data[7];
            bit_cnt <= 4'd1;
          end else if (st == ST_RDAT) begin
            st      <= ST_LOCKOUT;
            oe      <= 1'b0;
            bit_cnt <= '0;
          end else begin
            st      <= st_nxt_q;
            oe      <= 1'b0;
            bit_cnt <= '0;
          end
        end
      end
    end
  end

  AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(oe)); // R1

  AST_LOCKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCKOUT) |-> !sda_drive_low); // R2

  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_byte_ev && (st == ST_DEV) && wr_busy) |=> !sda_drive_low); // R3

  AST_COMMIT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_ev)); // R6

  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end_ev && (st == ST_RDAT) && !host_ack && !start_ev && !stop_ev)
      |=> ((st == ST_LOCKOUT) && !sda_drive_low)); // R10

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> ((st == ST_DEV) && (bit_cnt == 4'd0) && !sda_drive_low)); // R11

endmodule

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;

  localparam int H = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_h = 1'b1;
  logic        sda_h = 1'b1;
  logic        sda_line;
  logic        sda_drive_low;
  logic [2:0]  strap = 3'b000;
  logic        wr_busy = 1'b0;
  logic        wr_valid;
  logic [13:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_commit;
  logic [13:0] rd_addr;
  logic [7:0]  rd_data;

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b10};
  endfunction

  assign sda_line = sda_h & ~sda_drive_low;
  assign rd_data  = pat(rd_addr);

  i2c_mem_target uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_h),
    .sda_in        (sda_line),
    .sda_drive_low (sda_drive_low),
    .strap         (strap),
    .wr_busy       (wr_busy),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_commit     (wr_commit),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data)
  );

  int checks = 0;
  int fails = 0;
  int wr_cnt = 0;
  int commit_cnt = 0;
  int hold_viol = 0;
  int quiet_viol = 0;
  bit watch_quiet = 1'b0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;
  logic [13:0] wr_a [16];
  logic [7:0]  wr_d [16];
  logic [13:0] model_ctr = '0;

  always @(negedge clk) begin
    if (wr_valid) begin
      if (wr_cnt < 16) begin
        wr_a[wr_cnt] = wr_addr;
        wr_d[wr_cnt] = wr_data;
      end
      wr_cnt++;
    end
    if (wr_commit) commit_cnt++;
    if (rst_n && scl_h && (sda_drive_low != prev_oe)) hold_viol++;
    if (watch_quiet && sda_drive_low) quiet_viol++;
    prev_oe = sda_drive_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_h = 1'b1; wait_clk(H);
    scl_h = 1'b1; wait_clk(H);
    sda_h = 1'b0; wait_clk(H);
    scl_h = 1'b0; wait_clk(4);
  endtask

  task automatic bus_stop;
    sda_h = 1'b0; wait_clk(H);
    scl_h = 1'b1; wait_clk(H);
    sda_h = 1'b1; wait_clk(H);
  endtask

  task automatic bus_bit(input logic b, output logic got);
    sda_h = b;    wait_clk(H);
    scl_h = 1'b1; wait_clk(H);
    got = sda_line;
    scl_h = 1'b0; wait_clk(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic g;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], g);
    bus_bit(1'b1, g);
    acked = !g;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] b);
    logic g;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, g);
      b = {b[6:0], g};
    end
    bus_bit(ack_it ? 1'b0 : 1'b1, g);
  endtask

  task automatic t_reset;
    chk(!sda_drive_low, "R12 sda released", sda_drive_low, 0);
    chk(!wr_valid, "R12 wr_valid low", wr_valid, 0);
    chk(!wr_commit, "R12 wr_commit low", wr_commit, 0);
  endtask

  task automatic t_page_write;
    bit a;
    int c0;
    c0 = commit_cnt;
    bus_start;
    send_byte(8'hA0, a); chk(a, "R2 write header ack", a, 1);
    send_byte(8'hC1, a); chk(a, "R4 word addr hi ack", a, 1);
    send_byte(8'h3E, a); chk(a, "R4 word addr lo ack", a, 1);
    for (int i = 0; i < 4; i++) begin
      send_byte(8'hA0 + 8'(i), a);
      chk(a, "R5 data byte ack", a, 1);
    end
    bus_stop;
    wait_clk(4);
    chk(wr_cnt == 4, "R5 write strobes", wr_cnt, 4);
    chk(wr_a[0] == 14'h013E, "R4 top bits ignored", wr_a[0], 14'h013E);
    chk(wr_a[1] == 14'h013F && wr_d[1] == 8'hA1, "R5 second byte", wr_a[1], 14'h013F);
    chk(wr_a[2] == 14'h0100, "R5 page wrap", wr_a[2], 14'h0100);
    chk(wr_a[3] == 14'h0101 && wr_d[3] == 8'hA3, "R5 after wrap", wr_a[3], 14'h0101);
    chk(commit_cnt == c0 + 1, "R6 commit on stop", commit_cnt, c0 + 1);
    model_ctr = 14'h0102;
  endtask

  task automatic t_current_read;
    bit a;
    logic [7:0] b;
    bus_start;
    send_byte(8'hA1, a); chk(a, "R7 read header ack", a, 1);
    recv_byte(1'b0, b);
    chk(b == pat(model_ctr), "R7 current address data", b, pat(model_ctr));
    bus_stop;
    model_ctr = model_ctr + 14'd1;
  endtask

  task automatic t_poll;
    bit a;
    int c0;
    c0 = commit_cnt;
    wr_busy = 1'b1;
    bus_start;
    send_byte(8'hA0, a); chk(!a, "R3 busy header not acked", a, 0);
    bus_stop;
    wr_busy = 1'b0;
    bus_start;
    send_byte(8'hA0, a); chk(a, "R3 idle header acked", a, 1);
    bus_stop;
    wait_clk(4);
    chk(commit_cnt == c0, "R6 no commit without data", commit_cnt, c0);
  endtask

  task automatic t_mismatch;
    bit a;
    strap = 3'b101;
    bus_start;
    watch_quiet = 1'b1;
    send_byte(8'hA0, a); chk(!a, "R2 wrong strap not acked", a, 0);
    send_byte(8'h55, a); chk(!a, "R2 lockout no ack", a, 0);
    watch_quiet = 1'b0;
    chk(quiet_viol == 0, "R2 no drive after mismatch", quiet_viol, 0);
    bus_stop;
    bus_start;
    send_byte(8'hAA, a); chk(a, "R2 strap 101 acked", a, 1);
    bus_stop;
    strap = 3'b000;
  endtask

  task automatic t_random_seq;
    bit a;
    logic g;
    logic [7:0] b;
    int c0;
    c0 = commit_cnt;
    bus_start;
    send_byte(8'hA0, a);
    send_byte(8'h3F, a);
    send_byte(8'hFE, a);
    bus_start;
    send_byte(8'hA1, a); chk(a, "R8 read after repeated start", a, 1);
    recv_byte(1'b1, b); chk(b == pat(14'h3FFE), "R8 random data", b, pat(14'h3FFE));
    recv_byte(1'b1, b); chk(b == pat(14'h3FFF), "R9 next byte", b, pat(14'h3FFF));
    recv_byte(1'b0, b); chk(b == pat(14'h0000), "R9 wrap to 0", b, pat(14'h0000));
    bus_bit(1'b1, g); chk(g == 1'b1, "R10 released after nack", g, 1);
    bus_stop;
    wait_clk(4);
    chk(commit_cnt == c0, "R6 dummy write no commit", commit_cnt, c0);
    model_ctr = 14'h0001;
  endtask

  task automatic t_top_current;
    bit a;
    logic [7:0] b;
    bus_start;
    send_byte(8'hA0, a);
    send_byte(8'h3F, a);
    send_byte(8'hFF, a);
    bus_start;
    send_byte(8'hA1, a);
    recv_byte(1'b0, b); chk(b == pat(14'h3FFF), "R8 top location", b, pat(14'h3FFF));
    bus_stop;
    model_ctr = 14'h0000;
    t_current_read;
  endtask

  task automatic t_abort;
    bit a;
    logic g;
    logic [7:0] b;
    bus_start;
    bus_bit(1'b1, g); bus_bit(1'b0, g); bus_bit(1'b1, g); bus_bit(1'b0, g);
    bus_start;
    send_byte(8'hA1, a); chk(a, "R11 header after abort acked", a, 1);
    recv_byte(1'b0, b); chk(b == pat(model_ctr), "R11 data after abort", b, pat(model_ctr));
    bus_stop;
    model_ctr = model_ctr + 14'd1;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    t_reset;
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_page_write;
    t_current_read;
    t_poll;
    t_mismatch;
    t_random_seq;
    t_top_current;
    t_abort;
    chk(hold_viol == 0, "R1 drive changes only with SCL low", hold_viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule